// File: doc/BRIEF.md
# Width-Merging Integer ALU

This block is the integer execution unit of a micro-op core in which every operation carries a two-bit size code. The unit takes an opcode, the size code, a first operand that also holds the previous contents of the destination register, and a second operand. It produces a 64-bit register value and five status flags that travel with that value. When an operation is narrower than the register, the new bits are merged into the previous destination contents inside the unit, so a narrow register write never needs a separate merge micro-op.

The supported operations are add, subtract, and, or, exclusive-or, a size-merging move and a byte insert. The byte insert can place a byte in the second byte of a register (bits 15:8), which serves the legacy second-byte register names. Arithmetic and flags are evaluated combinationally at the selected width. The result and the flags are captured in one output register stage together with a valid bit.

Top module: `merge_alu`

## Requirements
- R1: The size input selects the operation width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. All arithmetic, logic and flags are evaluated at that width.
- R2: At widths 8 and 16, only the low 8 or 16 result bits replace the matching bits of `src_a`. Bits above the width are copied from `src_a` unchanged.
- R3: At width 32, the result is zero-extended to 64 bits. At width 64, the full result is written.
- R4: Opcode 0 (add) and opcode 1 (sub) produce `src_a + src_b` and `src_a - src_b` modulo 2^width. Carry is the unsigned carry out of the top bit of the width for add, and the borrow (`src_a < src_b` unsigned at that width) for sub. Overflow is signed overflow at the width.
- R5: Opcode 6 (byte insert) takes `src_b[7:0]` and writes it to bits 15:8 of `src_a` when `hi_lane` is 1, or to bits 7:0 when `hi_lane` is 0. All other bits of `src_a` pass through and the size input is ignored. Zero, parity and sign are taken from the inserted byte. Carry and overflow are 0.
- R6: Opcodes 2, 3 and 4 (and, or, xor) and opcode 5 (move, which yields `src_b`) clear carry and overflow. The move obeys the size merge of R2 and R3. Opcode 7 returns `src_a` unchanged with all flags 0.
- R7: Zero is 1 when the result at the operation width is all zeros. Sign is the top bit of the width. Parity is 1 when the low 8 result bits contain an even number of ones.
- R8: `flags` bit order: bit 4 zero, bit 3 parity, bit 2 sign, bit 1 overflow, bit 0 carry.
- R9: Operations issued with `in_valid` high appear on `result` and `flags` one clock later, with `out_valid` high. When `in_valid` is low, `out_valid` drops on the next clock while `result` and `flags` hold their values.
- R10: While `rst_n` is low, `out_valid`, `result` and `flags` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Opcode (see R4 to R6) |
| size | input | 2 | Operation width code |
| hi_lane | input | 1 | Byte-insert target lane: 1 selects bits 15:8 |
| src_a | input | 64 | First operand and previous destination value |
| src_b | input | 64 | Second operand |
| out_valid | output | 1 | Registered result valid |
| result | output | 64 | Merged destination value |
| flags | output | 5 | {zero, parity, sign, overflow, carry} |

## Verification
The only internal state is the output register. A wrong width selection or a faulty merge therefore shows up on `result` exactly one clock after the offending operation, either as corrupted upper bits of the old destination or as missing zero extension. Flag faults show up on the same edge, most visibly at the carry and signed-overflow boundaries of each width. A capture or hold fault shows up as a changed `result` in the cycle after an idle input cycle.

// File: rtl/merge_alu_pkg.sv
package merge_alu_pkg;
  localparam int XLEN   = 64;
  localparam int BYTE_W = 8;
  localparam int NSIZE  = 4;
  localparam int NFLAG  = 5;
  localparam int OP_W   = 3;
  localparam int SZ_W   = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_MOV = 3'd5,
    OP_INS = 3'd6,
    OP_NOP = 3'd7
  } alu_op_e;

  typedef enum logic [SZ_W-1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } alu_size_e;

  typedef struct packed {
    logic zf;
    logic pf;
    logic sf;
    logic of;
    logic cf;
  } alu_flags_t;

  function automatic logic even_parity8(input logic [BYTE_W-1:0] v);
    return ~(^v);
  endfunction

  function automatic logic add_ovf(input logic a_msb, input logic b_msb, input logic r_msb);
    return (a_msb == b_msb) && (r_msb != a_msb);
  endfunction

  function automatic logic sub_ovf(input logic a_msb, input logic b_msb, input logic r_msb);
    return (a_msb != b_msb) && (r_msb != a_msb);
  endfunction
endpackage

// File: rtl/merge_alu_lanes.sv
module merge_alu_lanes
  import merge_alu_pkg::*;
#(
  parameter int XW = XLEN
) (
  input  logic [OP_W-1:0] op,
  input  logic [SZ_W-1:0] size,
  input  logic [XW-1:0]   src_a,
  input  logic [XW-1:0]   src_b,
  output logic [XW-1:0]   raw_res,
  output alu_flags_t      raw_flags
);
  logic [XW-1:0] lane_res [NSIZE];
  logic          lane_cf  [NSIZE];
  logic          lane_of  [NSIZE];
  logic          lane_sf  [NSIZE];

  for (genvar g = 0; g < NSIZE; g++) begin : g_lane
    localparam int W = BYTE_W << g;
    logic [W:0]   s_add;
    logic [W:0]   s_sub;
    logic [W-1:0] r;
    logic         cf;
    logic         of;

    assign s_add = {1'b0, src_a[W-1:0]} + {1'b0, src_b[W-1:0]};
    assign s_sub = {1'b0, src_a[W-1:0]} - {1'b0, src_b[W-1:0]};

    always_comb begin
      r  = '0;
      cf = 1'b0;
      of = 1'b0;
      case (op)
        OP_ADD: begin
          r  = s_add[W-1:0];
          cf = s_add[W];
          of = add_ovf(src_a[W-1], src_b[W-1], s_add[W-1]);
        end
        OP_SUB: begin
          r  = s_sub[W-1:0];
          cf = s_sub[W];
          of = sub_ovf(src_a[W-1], src_b[W-1], s_sub[W-1]);
        end
        OP_AND:  r = src_a[W-1:0] & src_b[W-1:0];
        OP_OR:   r = src_a[W-1:0] | src_b[W-1:0];
        OP_XOR:  r = src_a[W-1:0] ^ src_b[W-1:0];
        OP_MOV:  r = src_b[W-1:0];
        default: r = '0;
      endcase
    end

    always_comb begin
      lane_res[g]        = '0;
      lane_res[g][W-1:0] = r;
    end
    assign lane_cf[g] = cf;
    assign lane_of[g] = of;
    assign lane_sf[g] = r[W-1];
  end

  logic is_ins;
  logic is_nop;
  assign is_ins = (op == OP_INS);
  assign is_nop = (op == OP_NOP);

  always_comb begin
    if (is_ins) begin
      raw_res              = '0;
      raw_res[BYTE_W-1:0]  = src_b[BYTE_W-1:0];
      raw_flags.cf         = 1'b0;
      raw_flags.of         = 1'b0;
      raw_flags.sf         = src_b[BYTE_W-1];
    end else begin
      raw_res      = lane_res[size];
      raw_flags.cf = lane_cf[size];
      raw_flags.of = lane_of[size];
      raw_flags.sf = lane_sf[size];
    end
    raw_flags.zf = (raw_res == '0);
    raw_flags.pf = even_parity8(raw_res[BYTE_W-1:0]);
    if (is_nop) raw_flags = '0;
  end
endmodule

// File: rtl/merge_alu_merge.sv
module merge_alu_merge
  import merge_alu_pkg::*;
#(
  parameter int XW = XLEN
) (
  input  logic [SZ_W-1:0] size,
  input  logic            ins_mode,
  input  logic            keep_dest,
  input  logic            hi_lane,
  input  logic [XW-1:0]   old_dest,
  input  logic [XW-1:0]   raw_res,
  output logic [XW-1:0]   merged
);
  localparam int HALF_W = 2 * BYTE_W;

  always_comb begin
    merged = old_dest;
    if (keep_dest) begin
      merged = old_dest;
    end else if (ins_mode) begin
      if (hi_lane) merged[HALF_W-1:BYTE_W] = raw_res[BYTE_W-1:0];
      else         merged[BYTE_W-1:0]      = raw_res[BYTE_W-1:0];
    end else begin
      case (size)
        SZ_8:    merged[BYTE_W-1:0] = raw_res[BYTE_W-1:0];
        SZ_16:   merged[HALF_W-1:0] = raw_res[HALF_W-1:0];
        default: merged = raw_res;
      endcase
    end
  end
endmodule

// File: rtl/merge_alu.sv
module merge_alu
  import merge_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  op,
  input  logic [1:0]  size,
  input  logic        hi_lane,
  input  logic [63:0] src_a,
  input  logic [63:0] src_b,
  output logic        out_valid,
  output logic [63:0] result,
  output logic [4:0]  flags
);
  logic [XLEN-1:0] raw_res;
  alu_flags_t      raw_flags;
  logic [XLEN-1:0] merged;
  logic            ins_mode;
  logic            keep_dest;

  assign ins_mode  = (op == OP_INS);
  assign keep_dest = (op == OP_NOP);

  merge_alu_lanes #(.XW(XLEN)) u_lanes (
    .op       (op),
    .size     (size),
    .src_a    (src_a),
    .src_b    (src_b),
    .raw_res  (raw_res),
    .raw_flags(raw_flags)
  );

  merge_alu_merge #(.XW(XLEN)) u_merge (
    .size     (size),
    .ins_mode (ins_mode),
    .keep_dest(keep_dest),
    .hi_lane  (hi_lane),
    .old_dest (src_a),
    .raw_res  (raw_res),
    .merged   (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= merged;
        flags  <= raw_flags;
      end
    end
  end
endmodule

// File: rtl/merge_alu_chk.sv
module merge_alu_chk
  import merge_alu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  op,
  input logic [1:0]  size,
  input logic        hi_lane,
  input logic [63:0] src_a,
  input logic        out_valid,
  input logic [63:0] result,
  input logic [4:0]  flags
);
  logic narrow8, narrow16, wide32, logic_op, ins_op;
  assign narrow8  = in_valid && (size == SZ_8)  && (op <= OP_MOV);
  assign narrow16 = in_valid && (size == SZ_16) && (op <= OP_MOV);
  assign wide32   = in_valid && (size == SZ_32) && (op <= OP_MOV);
  assign logic_op = in_valid && (op >= OP_AND);
  assign ins_op   = in_valid && (op == OP_INS);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(flags)); // R9
  AST_KEEP_UPPER8: assert property (@(posedge clk) disable iff (!rst_n)
    narrow8 |=> result[63:8] == $past(src_a[63:8])); // R2
  AST_KEEP_UPPER16: assert property (@(posedge clk) disable iff (!rst_n)
    narrow16 |=> result[63:16] == $past(src_a[63:16])); // R2
  AST_ZERO_EXT32: assert property (@(posedge clk) disable iff (!rst_n)
    wide32 |=> result[63:32] == 32'd0); // R3
  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    logic_op |=> flags[1:0] == 2'b00); // R6
  AST_INS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ins_op |=> result[63:16] == $past(src_a[63:16])); // R5
  AST_INS_OTHER_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_op && hi_lane |=> result[7:0] == $past(src_a[7:0])); // R5
endmodule

bind merge_alu merge_alu_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .op       (op),
  .size     (size),
  .hi_lane  (hi_lane),
  .src_a    (src_a),
  .out_valid(out_valid),
  .result   (result),
  .flags    (flags)
);

// File: tb/sim_merge_alu.sv
module sim_merge_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [1:0]  size = 2'd0;
  logic        hi_lane = 1'b0;
  logic [63:0] src_a = 64'd0;
  logic [63:0] src_b = 64'd0;
  logic        out_valid;
  logic [63:0] result;
  logic [4:0]  flags;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic        exp_valid = 1'b0;
  logic [63:0] exp_res = 64'd0;
  logic [4:0]  exp_flags = 5'd0;
  string       exp_tag = "R10";

  always #2 clk = ~clk;

  merge_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
    .hi_lane(hi_lane), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .result(result), .flags(flags)
  );

  function automatic int popc8(input logic [63:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n;
  endfunction

  // Behavioural model of R1..R8: returns merged value and packs flags.
  function automatic void model(input logic [2:0] o, input logic [1:0] s, input logic hl,
                                input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] res, output logic [4:0] fl,
                                output string tag);
    int          w;
    logic [63:0] m, av, bv, r;
    logic [64:0] wide;
    logic        zf, pf, sf, of, cf;
    w  = 8 * (1 << s);                         // R1
    m  = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    av = a & m;
    bv = b & m;
    cf = 0; of = 0; r = 0;
    tag = "R6";
    if (o == 3'd0) begin                       // R4 add
      wide = {1'b0, av} + {1'b0, bv};
      r = wide[63:0] & m; cf = wide[w];
      of = (av[w-1] == bv[w-1]) && (r[w-1] != av[w-1]);
      tag = "R4";
    end else if (o == 3'd1) begin              // R4 sub
      r = (av - bv) & m; cf = (av < bv);
      of = (av[w-1] != bv[w-1]) && (r[w-1] != av[w-1]);
      tag = "R4";
    end else if (o == 3'd2) r = av & bv;
    else if (o == 3'd3) r = av | bv;
    else if (o == 3'd4) r = av ^ bv;
    else if (o == 3'd5) r = bv;
    if (o == 3'd6) begin                       // R5
      r = {56'd0, b[7:0]};
      res = hl ? ((a & ~64'hFF00) | (r << 8)) : ((a & ~64'hFF) | r);
      zf = (r == 0); pf = (popc8(r) % 2 == 0); sf = r[7];
      fl = {zf, pf, sf, 1'b0, 1'b0};
      tag = "R5";
      return;
    end
    if (o == 3'd7) begin                       // R6 reserved code
      res = a; fl = 5'd0; return;
    end
    zf = (r == 0); sf = r[w-1]; pf = (popc8(r) % 2 == 0);   // R7
    if (w < 32) begin res = (a & ~m) | r; tag = (o <= 1) ? "R4/R2" : "R6/R2"; end
    else res = r;                              // R3 zero-extension or full
    if (w == 32) tag = (o <= 1) ? "R4/R3" : "R6/R3";
    fl = {zf, pf, sf, of, cf};                 // R8
  endfunction

  task automatic check_out();
    n_checks++;
    if (out_valid !== exp_valid) begin
      n_fail++;
      $display("FAIL R9 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
    end
    n_checks++;
    if (result !== exp_res) begin
      n_fail++;
      $display("FAIL %s result actual=%h expected=%h", exp_tag, result, exp_res);
    end
    n_checks++;
    if (flags !== exp_flags) begin
      n_fail++;
      $display("FAIL %s/R7/R8 flags actual=%b expected=%b", exp_tag, flags, exp_flags);
    end
  endtask

  // Drive one cycle at a falling edge, then check after the next rising edge.
  task automatic step(input logic v, input logic [2:0] o, input logic [1:0] s,
                      input logic hl, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    logic [4:0]  f;
    string       t;
    in_valid = v; op = o; size = s; hi_lane = hl; src_a = a; src_b = b;
    model(o, s, hl, a, b, r, f, t);
    exp_valid = v;
    if (v) begin exp_res = r; exp_flags = f; exp_tag = t; end
    else exp_tag = "R9";
    @(negedge clk);
    check_out();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_out();                               // R10 reset state
    rst_n = 1'b1;
    @(negedge clk);
    // R4 R2: 8-bit add wraps to zero with carry, upper bits kept
    step(1, 3'd0, 2'd0, 0, 64'h11223344556677FF, 64'h01);
    // R4: 16-bit signed overflow
    step(1, 3'd0, 2'd1, 0, 64'hAAAA_BBBB_CCCC_7FFF, 64'h1);
    // R4 R3: 32-bit borrow, zero-extended
    step(1, 3'd1, 2'd2, 0, 64'hFFFF_FFFF_0000_0000, 64'h1);
    // R4: 64-bit add carry out
    step(1, 3'd0, 2'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2);
    // R4: 64-bit sub signed overflow
    step(1, 3'd1, 2'd3, 0, 64'h8000_0000_0000_0000, 64'h1);
    // R6 R2: byte move merges
    step(1, 3'd5, 2'd0, 0, 64'h0123456789ABCDEF, 64'hFFFF_FFFF_FFFF_FF5A);
    // R6: logical ops clear carry/overflow
    step(1, 3'd2, 2'd3, 0, 64'hF0F0, 64'h0F0F);
    step(1, 3'd4, 2'd1, 0, 64'h1234_5678_9ABC_8001, 64'h0001);
    // R5: insert into second byte, then low byte, size ignored
    step(1, 3'd6, 2'd3, 1, 64'h1122334455667788, 64'hC3);
    step(1, 3'd6, 2'd2, 0, 64'h1122334455667788, 64'h00);
    // R6: reserved code keeps destination
    step(1, 3'd7, 2'd3, 0, 64'hDEAD_BEEF_0000_1111, 64'h5);
    // R9: idle cycles hold result
    step(0, 3'd0, 2'd3, 0, 64'h5, 64'h6);
    step(0, 3'd1, 2'd0, 1, 64'h9, 64'h7);
    // Mixed patterns, with edge operands
    for (int i = 0; i < 600; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 7 == 0) b = a;
      if (i % 11 == 0) a = 64'h7FFF_FFFF_7FFF_7F7F;
      step(($urandom % 5) != 0, 3'($urandom), 2'($urandom), 1'($urandom), a, b);
    end
    // R10: reset mid-stream clears outputs
    step(1, 3'd0, 2'd3, 0, 64'h10, 64'h20);
    rst_n = 1'b0;
    #1;
    exp_valid = 0; exp_res = 0; exp_flags = 0; exp_tag = "R10";
    check_out();
    finish_run();
  end
endmodule